// File: doc/BRIEF.md
# Receive Drop Log and Interrupt Unit

This unit sits beside a receive packet filter and records why packets were thrown away. Each packet the filter finishes presents a valid strobe, an L2-address-hit flag, a five-bit vector of drop reasons and a bad-checksum flag. The unit logs the reasons of the first drop that is not masked. It then freezes that log and raises a packet-drop interrupt status bit. The log records nothing new until software clears that bit. Two table parity checkers report errors with a failing address. Each error sets its own status bit and keeps the address of its first failure.

Software reaches everything through a flat word-addressed host port. Status bits are cleared by writing 1 to them. A mask register keeps selected status bits from driving the interrupt line. A debug register lets software raise any interrupt source directly, and the same mask applies to it. Two saturating counters track drops and bad checksums on L2-matched packets. Each counter clears when it is read.

Top module: `drop_log_irq`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Register word addresses: 0 status, 1 interrupt mask, 2 debug raise, 3 drop log, 4 log mask, 5 VLAN parity address, 6 lookup parity address, 7 drop counter, 8 bad-checksum counter.
- R2: A packet (`pkt_valid`=1) with a drop reason not masked by the log mask, presented while status bit 2 is 0, loads the drop log with `pkt_why & ~logmask` and sets status bit 2 at the next clock. Reason bits are 0 VLAN non-member, 1 lookup-table result, 2 class code, 3 L2 address mismatch, 4 TCP control bits.
- R3: A log-mask bit set to 1 removes that reason from the log. A packet whose reasons are all masked captures nothing and leaves status bit 2 at 0.
- R4: While status bit 2 is 1, further drops leave the log unchanged. Writing 1 to status bit 2 clears the log and re-arms capture. A qualifying drop in the same cycle as that write is captured, and the bit stays 1.
- R5: Status bits are cleared only by writing 1 to them. Writing 0 leaves them unchanged. The status layout is bit 0 VLAN parity, bit 1 lookup parity, bit 2 packet drop.
- R6: `irq` equals the OR, over bits 0 to 2, of (status OR debug-raise) AND NOT interrupt-mask. A mask bit of 1 blocks that source.
- R7: A VLAN (lookup) parity error sets status bit 0 (1) and latches its 12-bit (8-bit) address only if the bit was clear. Later errors keep the first address. Clearing the status bit also clears the address.
- R8: The drop counter increments on each valid packet with `pkt_l2_hit`=1 and any reason bit set, whatever the log masks or frozen state. The bad-checksum counter increments on each valid packet with `pkt_l2_hit`=1 and `pkt_bad_csum`=1. Packets with `pkt_l2_hit`=0 are not counted.
- R9: A counter read returns the count before the read and clears the counter. An increment in the same cycle as the read leaves the counter at 1.
- R10: A counter at its all-ones value stays there on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | One packet decision this cycle |
| pkt_l2_hit | input | 1 | Packet destination address matched |
| pkt_why | input | 5 | Drop-reason vector |
| pkt_bad_csum | input | 1 | Packet TCP/UDP checksum was bad |
| vpar_err | input | 1 | VLAN table parity error strobe |
| vpar_addr | input | VADDR_W | Failing VLAN table address |
| tpar_err | input | 1 | Lookup result table parity error strobe |
| tpar_addr | input | TADDR_W | Failing lookup table address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (drives clear-on-read) |
| host_addr | input | ADDR_W | Register word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for host_addr, same cycle |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach is a re-arming write and a qualifying drop in the same cycle. The bench reaches it with a single-cycle stimulus task that drives the host port and the packet inputs together. The same task makes a counter read coincide with an increment. Counter saturation cannot be reached at 32 bits, so the bench uses an 8-bit counter. A sweep over every log mask and every reason vector drives that counter to its ceiling.

// File: rtl/dlog_pkg.sv
package dlog_pkg;
   localparam int unsigned NUM_WHY  = 5;
   localparam int unsigned NUM_SRC  = 3;
   localparam int unsigned NUM_REGS = 9;

   localparam logic [3:0] RA_STAT  = 4'd0;
   localparam logic [3:0] RA_IMASK = 4'd1;
   localparam logic [3:0] RA_DBG   = 4'd2;
   localparam logic [3:0] RA_LOG   = 4'd3;
   localparam logic [3:0] RA_LMASK = 4'd4;
   localparam logic [3:0] RA_VADR  = 4'd5;
   localparam logic [3:0] RA_TADR  = 4'd6;
   localparam logic [3:0] RA_DCNT  = 4'd7;
   localparam logic [3:0] RA_BCNT  = 4'd8;

   localparam int unsigned SRC_VPAR = 0;
   localparam int unsigned SRC_TPAR = 1;
   localparam int unsigned SRC_DROP = 2;

   localparam int unsigned CNT_DROP = 0;
   localparam int unsigned CNT_BAD  = 1;
endpackage

// File: rtl/dlog_sat_counter.sv
module dlog_sat_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         rd_clr,
   output logic [W-1:0] value
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   initial begin : chk_w
      if (W < 2) $error("dlog_sat_counter: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      value <= '0;
      else if (rd_clr)                 value <= W'(inc);
      else if (inc && value != MAXV)   value <= value + 1'b1;
   end

   p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !rd_clr && value == MAXV) |=> value == MAXV);
   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !rd_clr && value != MAXV) |=> value == $past(value) + 1'b1);
   p_read_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && inc) |=> value == W'(1));
   p_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !inc) |=> value == '0);
endmodule

// File: rtl/dlog_err_latch.sv
module dlog_err_latch #(
   parameter int unsigned AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          err,
   input  logic [AW-1:0] err_addr,
   input  logic          clr,
   output logic          flag,
   output logic [AW-1:0] addr_q
);
   initial begin : chk_aw
      if (AW < 1) $error("dlog_err_latch: AW must be positive");
   end

   logic take;
   assign take = err && (!flag || clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         addr_q <= '0;
      end else if (take) begin
         flag   <= 1'b1;
         addr_q <= err_addr;
      end else if (clr) begin
         flag   <= 1'b0;
         addr_q <= '0;
      end
   end

   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> (flag && $stable(addr_q)));
   p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> flag);
endmodule

// File: rtl/dlog_capture.sv
module dlog_capture #(
   parameter int unsigned NR = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pkt_valid,
   input  logic [NR-1:0] why,
   input  logic [NR-1:0] log_mask,
   input  logic          clr,
   output logic          flag,
   output logic [NR-1:0] log_q
);
   initial begin : chk_nr
      if (NR < 1) $error("dlog_capture: NR must be positive");
   end

   logic [NR-1:0] kept;
   logic          hit, take;
   assign kept = why & ~log_mask;
   assign hit  = pkt_valid && (|kept);
   assign take = hit && (!flag || clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         log_q <= '0;
      end else if (take) begin
         flag  <= 1'b1;
         log_q <= kept;
      end else if (clr) begin
         flag  <= 1'b0;
         log_q <= '0;
      end
   end

   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> (flag && $stable(log_q)));
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !flag && (|(why & ~log_mask))) |=> flag);
   p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !(pkt_valid && (|(why & ~log_mask)))) |=> !flag);
endmodule

// File: rtl/drop_log_irq.sv
module drop_log_irq
   import dlog_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned VADDR_W = 12,
   parameter int unsigned TADDR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pkt_valid,
   input  logic               pkt_l2_hit,
   input  logic [4:0]         pkt_why,
   input  logic               pkt_bad_csum,
   input  logic               vpar_err,
   input  logic [VADDR_W-1:0] vpar_addr,
   input  logic               tpar_err,
   input  logic [TADDR_W-1:0] tpar_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               irq
);
   initial begin : chk_params
      if (ADDR_W < 4)        $error("drop_log_irq: ADDR_W too small for %0d registers", NUM_REGS);
      if (DATA_W < CNT_W)    $error("drop_log_irq: DATA_W narrower than CNT_W");
      if (DATA_W < VADDR_W)  $error("drop_log_irq: DATA_W narrower than VADDR_W");
      if (DATA_W < TADDR_W)  $error("drop_log_irq: DATA_W narrower than TADDR_W");
      if (DATA_W < NUM_WHY)  $error("drop_log_irq: DATA_W narrower than reason vector");
   end

   function automatic logic sel(input logic [ADDR_W-1:0] a, input logic [3:0] ra);
      return a == ADDR_W'(ra);
   endfunction

   // host decode
   logic [NUM_SRC-1:0] w1c;
   assign w1c = (host_wr && sel(host_addr, RA_STAT)) ? host_wdata[NUM_SRC-1:0] : '0;

   logic [NUM_SRC-1:0] imask_q, dbg_q;
   logic [NUM_WHY-1:0] lmask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imask_q <= '0;
         dbg_q   <= '0;
         lmask_q <= '0;
      end else if (host_wr) begin
         if (sel(host_addr, RA_IMASK)) imask_q <= host_wdata[NUM_SRC-1:0];
         if (sel(host_addr, RA_DBG))   dbg_q   <= host_wdata[NUM_SRC-1:0];
         if (sel(host_addr, RA_LMASK)) lmask_q <= host_wdata[NUM_WHY-1:0];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^host_wdata[DATA_W-1:NUM_WHY];

   // status sources
   logic [NUM_SRC-1:0] stat;
   logic [NUM_WHY-1:0] log_q;
   logic [VADDR_W-1:0] vadr_q;
   logic [TADDR_W-1:0] tadr_q;

   dlog_err_latch #(.AW(VADDR_W)) u_vpar (
      .clk(clk), .rst_n(rst_n), .err(vpar_err), .err_addr(vpar_addr),
      .clr(w1c[SRC_VPAR]), .flag(stat[SRC_VPAR]), .addr_q(vadr_q));

   dlog_err_latch #(.AW(TADDR_W)) u_tpar (
      .clk(clk), .rst_n(rst_n), .err(tpar_err), .err_addr(tpar_addr),
      .clr(w1c[SRC_TPAR]), .flag(stat[SRC_TPAR]), .addr_q(tadr_q));

   dlog_capture #(.NR(NUM_WHY)) u_cap (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .why(pkt_why),
      .log_mask(lmask_q), .clr(w1c[SRC_DROP]), .flag(stat[SRC_DROP]), .log_q(log_q));

   // counters
   logic [1:0]       cnt_inc, cnt_rd;
   logic [CNT_W-1:0] cnt_val [2];

   assign cnt_inc[CNT_DROP] = pkt_valid && pkt_l2_hit && (|pkt_why);
   assign cnt_inc[CNT_BAD]  = pkt_valid && pkt_l2_hit && pkt_bad_csum;
   assign cnt_rd[CNT_DROP]  = host_rd && sel(host_addr, RA_DCNT);
   assign cnt_rd[CNT_BAD]   = host_rd && sel(host_addr, RA_BCNT);

   for (genvar i = 0; i < 2; i++) begin : g_cnt
      dlog_sat_counter #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(cnt_inc[i]), .rd_clr(cnt_rd[i]),
         .value(cnt_val[i]));
   end

   // interrupt
   assign irq = |((stat | dbg_q) & ~imask_q);

   // read mux
   always_comb begin
      host_rdata = '0;
      if      (sel(host_addr, RA_STAT))  host_rdata = DATA_W'(stat);
      else if (sel(host_addr, RA_IMASK)) host_rdata = DATA_W'(imask_q);
      else if (sel(host_addr, RA_DBG))   host_rdata = DATA_W'(dbg_q);
      else if (sel(host_addr, RA_LOG))   host_rdata = DATA_W'(log_q);
      else if (sel(host_addr, RA_LMASK)) host_rdata = DATA_W'(lmask_q);
      else if (sel(host_addr, RA_VADR))  host_rdata = DATA_W'(vadr_q);
      else if (sel(host_addr, RA_TADR))  host_rdata = DATA_W'(tadr_q);
      else if (sel(host_addr, RA_DCNT))  host_rdata = DATA_W'(cnt_val[CNT_DROP]);
      else if (sel(host_addr, RA_BCNT))  host_rdata = DATA_W'(cnt_val[CNT_BAD]);
   end

   p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (&imask_q) |-> !irq);
   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c[SRC_VPAR] && !vpar_err) |=> !stat[SRC_VPAR]);
   p_no_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[SRC_TPAR] && !w1c[SRC_TPAR]) |=> stat[SRC_TPAR]);
endmodule

// File: tb/drop_log_irq_test.sv
module drop_log_irq_test;
   localparam int CW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 0, pkt_l2_hit = 0, pkt_bad_csum = 0;
   logic [4:0]  pkt_why = '0;
   logic        vpar_err = 0, tpar_err = 0;
   logic [11:0] vpar_addr = '0;
   logic [7:0]  tpar_addr = '0;
   logic        host_wr = 0, host_rd = 0;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        irq;

   drop_log_irq #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_l2_hit(pkt_l2_hit),
      .pkt_why(pkt_why), .pkt_bad_csum(pkt_bad_csum), .vpar_err(vpar_err),
      .vpar_addr(vpar_addr), .tpar_err(tpar_err), .tpar_addr(tpar_addr),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq));

   always #2 clk = ~clk;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [31:0] rv;
   logic        iv;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [31:0] wd, input logic pv, input logic l2,
                       input logic [4:0] why, input logic bad, input logic ve,
                       input logic [11:0] va, input logic te, input logic [7:0] ta);
      host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
      pkt_valid = pv; pkt_l2_hit = l2; pkt_why = why; pkt_bad_csum = bad;
      vpar_err = ve; vpar_addr = va; tpar_err = te; tpar_addr = ta;
      #1;
      rv = host_rdata;
      iv = irq;
      @(negedge clk);
      host_wr = 0; host_rd = 0; pkt_valid = 0; vpar_err = 0; tpar_err = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(1, 0, a, d, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic rd(input logic [3:0] a);
      step(0, 1, a, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic pkt(input logic l2, input logic [4:0] why, input logic bad);
      step(0, 0, 0, 0, 1, l2, why, bad, 0, 0, 0, 0);
   endtask
   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      for (int a = 0; a < 9; a++) begin
         rd(4'(a));
         check("R1 reset reg", rv, 0);
      end
      idle(); check("R1 irq low", 32'(iv), 0);

      // R8 no counting without L2 hit; capture still happens (R2)
      pkt(0, 5'h01, 1);
      rd(7); check("R8 drop cnt l2 miss", rv, 0);
      rd(8); check("R8 bad cnt l2 miss", rv, 0);
      rd(3); check("R2 log l2 miss", rv, 32'h01);
      rd(0); check("R2 status drop", rv, 32'h4);
      idle(); check("R6 irq drop", 32'(iv), 1);
      wr(0, 4);

      // R4 frozen log, R5 write-zero, R6 mask
      pkt(1, 5'h01, 0);
      pkt(1, 5'h10, 0);
      rd(3); check("R4 log frozen", rv, 32'h01);
      rd(7); check("R8 drop cnt counts while frozen", rv, 2);
      wr(1, 4); idle(); check("R6 mask blocks drop", 32'(iv), 0);
      wr(1, 0); idle(); check("R6 unmask", 32'(iv), 1);
      wr(0, 0);
      rd(0); check("R5 write zero keeps", rv, 4);
      wr(0, 4);
      rd(0); check("R5 write one clears", rv, 0);
      rd(3); check("R4 log cleared on rearm", rv, 0);
      idle(); check("R6 irq low after clear", 32'(iv), 0);

      // R4 same-cycle clear and capture
      pkt(1, 5'h02, 0);
      step(1, 0, 0, 4, 1, 1, 5'h08, 0, 0, 0, 0, 0);
      rd(3); check("R4 same-cycle capture log", rv, 32'h08);
      rd(0); check("R4 same-cycle status", rv, 4);
      wr(0, 4);

      // R9 read clear with concurrent increment
      rd(7); check("R8 drop cnt", rv, 2);
      pkt(1, 5'h01, 0); pkt(1, 5'h01, 0); pkt(1, 5'h01, 0);
      step(0, 1, 7, 0, 1, 1, 5'h01, 0, 0, 0, 0, 0);
      check("R9 read returns old", rv, 3);
      rd(7); check("R9 increment kept as one", rv, 1);
      wr(0, 4);

      // R8 bad checksum counter
      pkt(1, 5'h00, 1); pkt(1, 5'h00, 1);
      rd(8); check("R8 bad cnt", rv, 2);
      rd(8); check("R9 bad cnt cleared", rv, 0);
      rd(0); check("R3 no reason no capture", rv, 0);
      rd(7); check("R8 no reason no count", rv, 0);

      // R7 parity logs
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 12'hABC, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 12'h123, 1, 8'h5A);
      rd(0); check("R7 parity status", rv, 3);
      rd(5); check("R7 vlan addr first kept", rv, 32'hABC);
      rd(6); check("R7 table addr", rv, 32'h5A);
      idle(); check("R6 irq parity", 32'(iv), 1);
      wr(1, 3); idle(); check("R6 parity masked", 32'(iv), 0);
      wr(1, 0);
      wr(0, 1);
      rd(5); check("R7 vlan addr cleared", rv, 0);
      rd(6); check("R7 table addr kept", rv, 32'h5A);
      rd(0); check("R5 only bit0 cleared", rv, 2);
      wr(0, 2);
      rd(6); check("R7 table addr cleared", rv, 0);

      // R6 debug raise x mask sweep
      for (int d = 0; d < 8; d++) begin
         for (int m = 0; m < 8; m++) begin
            wr(2, 32'(d)); wr(1, 32'(m)); idle();
            check("R6 debug/mask", 32'(iv), 32'(((d & ~m) & 7) != 0));
         end
      end
      wr(2, 0); wr(1, 0);

      // R2/R3 sweep over log mask and reasons; R10 saturation
      rd(7);
      for (int m = 0; m < 32; m++) begin
         wr(4, 32'(m));
         for (int r = 1; r < 32; r++) begin
            pkt(1, 5'(r), 0);
            rd(3); check("R3 log masked reasons", rv, 32'(r & ~m & 31));
            rd(0); check("R2 status after drop", rv, ((r & ~m & 31) != 0) ? 4 : 0);
            wr(0, 4);
         end
      end
      rd(7); check("R10 drop cnt saturates", rv, 32'((1 << CW) - 1));
      rd(7); check("R9 cleared after saturation", rv, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule